// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between a processor core and its memory system and turns every 16-bit address into a single target. The target may be main RAM, one of three ROMs (program, character and system), or one of several windows inside an I/O page. The I/O page holds a video controller, a sound controller, a colour nibble memory, two timer controllers, an expansion memory controller, an identification byte and open expansion space. The block also produces the offset that the chosen target sees, and it decides whether a write must land in RAM.

Banking is controlled by two registers that the processor reaches at addresses 0 and 1: a direction register and a port data register. The 3-bit bank value is the low part of the inverted direction register ORed with the data register. It is recomputed combinationally from the register outputs, so a write to either register changes the map for the very next access. The block owns the colour nibble memory and a self-toggling identification byte. These, and the two port registers, are the only targets whose read data the block supplies itself.

Top module: `mem_bank_map`

## Requirements
- R1: After a synchronous active-low reset both port registers read 0x00, `bank_cfg` is 3'b111 and the identification byte holds 0x55.
- R2: `bank_cfg` equals bits 2:0 of (NOT direction register) OR data register. Addresses 0x0000 and 0x0001 give `tgt_id` 11 with `tgt_off` equal to address bit 0, read back the direction and data registers respectively, and a write to either one is used by the decode of the next cycle.
- R3: Addresses 0x0002 to 0x9FFF and 0xC000 to 0xCFFF give `tgt_id` 0 (RAM) with `tgt_off` equal to the full address.
- R4: 0xA000 to 0xBFFF gives `tgt_id` 1 (program ROM, offset = address bits 12:0) when `bank_cfg[1:0]` is 2'b11, and RAM otherwise.
- R5: 0xE000 to 0xFFFF gives `tgt_id` 3 (system ROM, offset = address bits 12:0) when `bank_cfg[1]` is 1, and RAM otherwise.
- R6: 0xD000 to 0xDFFF gives RAM when `bank_cfg[1:0]` is 0. Otherwise it gives `tgt_id` 2 (character ROM, offset = address bits 11:0) when `bank_cfg[2]` is 0, and the I/O page when `bank_cfg[2]` is 1.
- R7: In the I/O page, address bits 11:8 of 0-3 give `tgt_id` 4 (video, offset bits 5:0). Values 4-7 give `tgt_id` 5 (sound, offset bits 4:0). Value C gives `tgt_id` 7 and value D gives `tgt_id` 8 (timers, offset bits 3:0).
- R8: In the I/O page, 0xDF00 to 0xDF0F give `tgt_id` 9 (expansion memory controller, offset bits 3:0) and 0xDFFF gives `tgt_id` 12 (identification byte, offset 0). Every other address with bits 11:8 of E or F gives `tgt_id` 10 (open space, offset bits 8:0).
- R9: `wr_ram` is high exactly when `cpu_wr` is high and `tgt_id` is 0, 1, 2 or 3. Writes at 0xE000 and above therefore always reach RAM, and I/O targets and port registers never do.
- R10: Bits 11:8 of 8 to B in the I/O page give `tgt_id` 6 (colour memory, offset bits 9:0). A write stores only data bits 3:0, and a read returns the stored nibble in bits 3:0. Bits 7:4 carry no defined value. A write while the colour target is not decoded leaves the memory unchanged.
- R11: Each cycle with `cpu_rd` high and `tgt_id` 12 inverts the identification byte, and the read returns the inverted value. Successive reads after reset therefore return 0xAA, 0x55, 0xAA. Writes, and reads of 0xDFFF while the I/O page is not mapped, leave it unchanged.
- R12: `rd_local` is high exactly for `tgt_id` 6, 11 and 12, and `rd_data` is 0x00 whenever `rd_local` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe for this cycle |
| cpu_wr | input | 1 | Write strobe for this cycle |
| tgt_id | output | 4 | Decoded target code (see requirements) |
| tgt_off | output | 16 | Offset within the decoded target |
| wr_ram | output | 1 | Write must be performed in RAM |
| rd_local | output | 1 | Read data is supplied by this block |
| rd_data | output | 8 | Read data for locally owned targets |
| bank_cfg | output | 3 | Current bank value |

## Verification
The bench sweeps every 256-byte page under all eight bank values and compares target, offset, local-read flag and write redirect against an arithmetic model. This catches swapped ROM conditions, a D page that ignores the zero-low-bits case, or an I/O nibble decoded off by one. Further directed cases cover banking when the direction register is not all ones, where a design that skips the inversion would map the wrong ROMs. Colour writes are checked for storing only the low nibble and for staying out of the memory when character ROM is mapped. The identification byte is checked for its first value of 0xAA and for not toggling on writes or on reads while the I/O page is not mapped.

// File: rtl/mbm_pkg.sv
// Package: shared target codes and field widths of the banked memory map.
// Assumes a 16-bit processor address and 8-bit data throughout.
package mbm_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int BANK_W    = 3;
    localparam int TGT_W     = 4;
    localparam int VID_OFF_W = 6;
    localparam int SND_OFF_W = 5;
    localparam int TMR_OFF_W = 4;
    localparam int EXP_OFF_W = 4;
    localparam int OPN_OFF_W = 9;

    typedef enum logic [TGT_W-1:0] {
        TGT_RAM      = 4'd0,
        TGT_PROG_ROM = 4'd1,
        TGT_CHAR_ROM = 4'd2,
        TGT_SYS_ROM  = 4'd3,
        TGT_VIDEO    = 4'd4,
        TGT_SOUND    = 4'd5,
        TGT_COLOR    = 4'd6,
        TGT_TIMER1   = 4'd7,
        TGT_TIMER2   = 4'd8,
        TGT_EXPMEM   = 4'd9,
        TGT_OPEN     = 4'd10,
        TGT_PORT     = 4'd11,
        TGT_IDREG    = 4'd12
    } tgt_e;

endpackage

// File: rtl/mbm_port_regs.sv
// Module: direction and data port registers that steer the memory banking.
// Assumes writes are qualified by the caller; sel picks data (1) or direction (0).
module mbm_port_regs
    import mbm_pkg::*;
#(
    parameter int REG_W = DATA_W,
    parameter int BNK_W = BANK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] dir_q,
    output logic [REG_W-1:0] dat_q,
    output logic [BNK_W-1:0] bank
);

    logic [REG_W-1:0] merged;

    // Register update: clear on reset, otherwise load the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (wr_en) begin
            if (sel) dat_q <= wdata;
            else     dir_q <= wdata;
        end
    end

    // Bank value: undriven (input) port lines read as ones.
    always_comb begin
        merged = ~dir_q | dat_q;
        bank   = merged[BNK_W-1:0];
    end

endmodule

// File: rtl/mbm_io_subdec.sv
// Module: sub-decoder for the I/O page, purely combinational.
// Assumes only the low 12 address bits are presented; the caller decides
// whether the I/O page is mapped at all.
module mbm_io_subdec
    import mbm_pkg::*;
#(
    parameter int COLOR_AW = 10
) (
    input  logic [11:0]       page_addr,
    output tgt_e              io_tgt,
    output logic [ADDR_W-1:0] io_off
);

    localparam logic [7:0]  EXP_HI  = 8'hF0;
    localparam logic [11:0] ID_ADDR = 12'hFFF;

    // Nibble decode of address bits 11:8 into a peripheral and its offset.
    always_comb begin
        io_tgt = TGT_OPEN;
        io_off = ADDR_W'(page_addr[OPN_OFF_W-1:0]);
        unique case (page_addr[11:8])
            4'h0, 4'h1, 4'h2, 4'h3: begin
                io_tgt = TGT_VIDEO;
                io_off = ADDR_W'(page_addr[VID_OFF_W-1:0]);
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                io_tgt = TGT_SOUND;
                io_off = ADDR_W'(page_addr[SND_OFF_W-1:0]);
            end
            4'h8, 4'h9, 4'hA, 4'hB: begin
                io_tgt = TGT_COLOR;
                io_off = ADDR_W'(page_addr[COLOR_AW-1:0]);
            end
            4'hC: begin
                io_tgt = TGT_TIMER1;
                io_off = ADDR_W'(page_addr[TMR_OFF_W-1:0]);
            end
            4'hD: begin
                io_tgt = TGT_TIMER2;
                io_off = ADDR_W'(page_addr[TMR_OFF_W-1:0]);
            end
            default: begin
                if (page_addr[11:4] == EXP_HI) begin
                    io_tgt = TGT_EXPMEM;
                    io_off = ADDR_W'(page_addr[EXP_OFF_W-1:0]);
                end else if (page_addr == ID_ADDR) begin
                    io_tgt = TGT_IDREG;
                    io_off = '0;
                end
            end
        endcase
    end

endmodule

// File: rtl/mbm_region_dec.sv
// Module: top-level region decode from address and bank value.
// Assumes the I/O sub-decode result is supplied for every address and is only
// used when the D page is mapped to I/O.
module mbm_region_dec
    import mbm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  tgt_e              io_tgt,
    input  logic [ADDR_W-1:0] io_off,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] off,
    output logic              ram_wr_ok
);

    logic low_any;
    logic prog_on;
    logic sys_on;

    // Bank conditions for each switchable window.
    always_comb begin
        low_any = |bank[1:0];
        prog_on = &bank[1:0];
        sys_on  = bank[1];
    end

    // Window selection by the top address nibble.
    always_comb begin
        tgt = TGT_RAM;
        off = addr;
        unique case (addr[15:12])
            4'hA, 4'hB: begin
                if (prog_on) begin
                    tgt = TGT_PROG_ROM;
                    off = ADDR_W'(addr[12:0]);
                end
            end
            4'hD: begin
                if (low_any) begin
                    if (bank[2]) begin
                        tgt = io_tgt;
                        off = io_off;
                    end else begin
                        tgt = TGT_CHAR_ROM;
                        off = ADDR_W'(addr[11:0]);
                    end
                end
            end
            4'hE, 4'hF: begin
                if (sys_on) begin
                    tgt = TGT_SYS_ROM;
                    off = ADDR_W'(addr[12:0]);
                end
            end
            default: begin
                if (addr[15:1] == '0) begin
                    tgt = TGT_PORT;
                    off = ADDR_W'(addr[0]);
                end
            end
        endcase
    end

    // Write redirect: RAM and every ROM window accept writes into RAM.
    always_comb begin
        ram_wr_ok = (tgt == TGT_RAM) || (tgt == TGT_PROG_ROM) ||
                    (tgt == TGT_CHAR_ROM) || (tgt == TGT_SYS_ROM);
    end

endmodule

// File: rtl/mbm_local_store.sv
// Module: storage the decoder owns itself: the colour nibble memory and the
// self-inverting identification byte, plus the read mux for local targets.
// Assumes tgt/idx come from the region decode of the same cycle.
module mbm_local_store
    import mbm_pkg::*;
#(
    parameter int             COLOR_DEPTH = 1024,
    parameter int             COLOR_W     = 4,
    parameter logic [DATA_W-1:0] ID_RESET = 8'h55,
    localparam int            COLOR_AW    = $clog2(COLOR_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tgt_e                tgt,
    input  logic [COLOR_AW-1:0] idx,
    input  logic                port_sel,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic [COLOR_W-1:0]  wnib,
    input  logic [DATA_W-1:0]   dir_q,
    input  logic [DATA_W-1:0]   dat_q,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_local
);

    logic [COLOR_W-1:0] col_mem [COLOR_DEPTH];
    logic [DATA_W-1:0]  id_q;
    logic               col_we;
    logic               id_rd;

    // Access strobes for the two stateful local targets.
    always_comb begin
        col_we = cpu_wr && (tgt == TGT_COLOR);
        id_rd  = cpu_rd && (tgt == TGT_IDREG);
    end

    // Colour memory write port: only the low nibble is kept.
    always_ff @(posedge clk) begin
        if (col_we) col_mem[idx] <= wnib;
    end

    // Identification byte: inverts on every decoded read.
    always_ff @(posedge clk) begin
        if (!rst_n)     id_q <= ID_RESET;
        else if (id_rd) id_q <= ~id_q;
    end

    // Local read mux; targets owned elsewhere return zero.
    always_comb begin
        rd_local = 1'b1;
        rd_data  = '0;
        unique case (tgt)
            TGT_PORT:  rd_data = port_sel ? dat_q : dir_q;
            TGT_COLOR: rd_data = DATA_W'(col_mem[idx]);
            TGT_IDREG: rd_data = ~id_q;
            default:   rd_local = 1'b0;
        endcase
    end

endmodule

// File: rtl/mem_bank_map.sv
// Module: banked memory map decoder top. Ties the port registers, the region
// decode, the I/O sub-decode and the locally owned storage together.
// Assumes one access per cycle, presented with address and strobes stable
// around the rising clock edge.
module mem_bank_map
    import mbm_pkg::*;
#(
    parameter int                COLOR_DEPTH = 1024,
    parameter int                COLOR_W     = 4,
    parameter logic [DATA_W-1:0] ID_RESET    = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [TGT_W-1:0]  tgt_id,
    output logic [ADDR_W-1:0] tgt_off,
    output logic              wr_ram,
    output logic              rd_local,
    output logic [DATA_W-1:0] rd_data,
    output logic [BANK_W-1:0] bank_cfg
);

    localparam int COLOR_AW = $clog2(COLOR_DEPTH);

    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] dat_q;
    logic              port_we;
    tgt_e              io_tgt;
    logic [ADDR_W-1:0] io_off;
    tgt_e              tgt;
    logic              ram_wr_ok;

    // Port register write strobe: addresses 0 and 1 only.
    always_comb begin
        port_we = cpu_wr && (cpu_addr[ADDR_W-1:1] == '0);
    end

    mbm_port_regs #(
        .REG_W (DATA_W),
        .BNK_W (BANK_W)
    ) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (port_we),
        .sel   (cpu_addr[0]),
        .wdata (cpu_wdata),
        .dir_q (dir_q),
        .dat_q (dat_q),
        .bank  (bank_cfg)
    );

    mbm_io_subdec #(
        .COLOR_AW (COLOR_AW)
    ) u_io (
        .page_addr (cpu_addr[11:0]),
        .io_tgt    (io_tgt),
        .io_off    (io_off)
    );

    mbm_region_dec u_dec (
        .addr      (cpu_addr),
        .bank      (bank_cfg),
        .io_tgt    (io_tgt),
        .io_off    (io_off),
        .tgt       (tgt),
        .off       (tgt_off),
        .ram_wr_ok (ram_wr_ok)
    );

    mbm_local_store #(
        .COLOR_DEPTH (COLOR_DEPTH),
        .COLOR_W     (COLOR_W),
        .ID_RESET    (ID_RESET)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt      (tgt),
        .idx      (tgt_off[COLOR_AW-1:0]),
        .port_sel (cpu_addr[0]),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .wnib     (cpu_wdata[COLOR_W-1:0]),
        .dir_q    (dir_q),
        .dat_q    (dat_q),
        .rd_data  (rd_data),
        .rd_local (rd_local)
    );

    // Output drive of the decoded target and the write redirect.
    always_comb begin
        tgt_id = tgt;
        wr_ram = cpu_wr && ram_wr_ok;
    end

endmodule

// File: rtl/mbm_checker.sv
// Module: property checker for mem_bank_map, attached by bind.
// Assumes it sees only the top-level ports.
module mbm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [3:0]  tgt_id,
    input logic        wr_ram,
    input logic [7:0]  rd_data,
    input logic [2:0]  bank_cfg
);

    logic past_ok;
    logic id_rd;

    // History guard: set after the first edge so $past has a defined value.
    always_ff @(posedge clk) past_ok <= 1'b1;

    // Identification read strobe as seen at the ports.
    always_comb id_rd = cpu_rd && (tgt_id == 4'd12);

    // R1: the cycle after reset the bank value is all ones.
    assert_rst_bank_R1: assert property (@(posedge clk)
        (past_ok && $past(!rst_n)) |-> (bank_cfg == 3'b111));

    // R2: the bank value only moves after a port register write.
    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[15:1] == 15'd0) |=> $stable(bank_cfg));

    // R4: program ROM is hidden unless both low bank bits are set.
    assert_prog_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b101 && bank_cfg[1:0] != 2'b11) |-> (tgt_id == 4'd0));

    // R8: full I/O bank maps the last address to the identification byte.
    assert_id_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == 16'hDFFF && bank_cfg == 3'b111) |-> (tgt_id == 4'd12));

    // R9: the top 8 KB always accepts writes into RAM.
    assert_high_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b111) |-> wr_ram);

    // R9: I/O and port targets never redirect into RAM.
    assert_io_no_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_id >= 4'd4) |-> !wr_ram);

    // R11: back-to-back identification reads return complementary bytes.
    assert_id_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rst_n) && id_rd && $past(id_rd)) |-> (rd_data == ~$past(rd_data)));

endmodule

bind mem_bank_map mbm_checker u_mbm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .tgt_id   (tgt_id),
    .wr_ram   (wr_ram),
    .rd_data  (rd_data),
    .bank_cfg (bank_cfg)
);

// File: tb/mem_bank_map_bench.sv
// Bench: page sweep under all bank values against an arithmetic model, plus
// directed cases for port registers, colour memory and identification byte.
module mem_bank_map_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [3:0]  tgt_id;
    logic [15:0] tgt_off;
    logic        wr_ram;
    logic        rd_local;
    logic [7:0]  rd_data;
    logic [2:0]  bank_cfg;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    mem_bank_map u_mem_bank_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .tgt_id    (tgt_id),
        .tgt_off   (tgt_off),
        .wr_ram    (wr_ram),
        .rd_local  (rd_local),
        .rd_data   (rd_data),
        .bank_cfg  (bank_cfg)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at addr %h: actual %0h expected %0h", req, cpu_addr, act, exp);
        end
    endtask

    // Model: target code from the requirement text.
    function automatic int m_code(input logic [15:0] a, input logic [2:0] b);
        if (a <= 16'h0001) return 11;
        case (a[15:12])
            4'hA, 4'hB: return (b[1:0] == 2'b11) ? 1 : 0;
            4'hE, 4'hF: return b[1] ? 3 : 0;
            4'hD: begin
                if (b[1:0] == 2'b00) return 0;
                if (!b[2]) return 2;
                if (a[11:8] < 4) return 4;
                if (a[11:8] < 8) return 5;
                if (a[11:8] < 12) return 6;
                if (a[11:8] == 4'hC) return 7;
                if (a[11:8] == 4'hD) return 8;
                if (a[15:4] == 12'hDF0) return 9;
                if (a == 16'hDFFF) return 12;
                return 10;
            end
            default: return 0;
        endcase
    endfunction

    // Model: offset for a target code.
    function automatic int m_off(input logic [15:0] a, input int c);
        case (c)
            0:  return int'(a);
            1, 3: return int'(a) % 8192;
            2:  return int'(a) % 4096;
            4:  return int'(a) % 64;
            5:  return int'(a) % 32;
            6:  return int'(a) % 1024;
            7, 8, 9: return int'(a) % 16;
            10: return int'(a) % 512;
            11: return int'(a) % 2;
            default: return 0;
        endcase
    endfunction

    function automatic string m_req(input int c);
        case (c)
            0: return "R3";
            1: return "R4";
            2: return "R6";
            3: return "R5";
            4, 5, 7, 8: return "R7";
            6: return "R10";
            11: return "R2";
            default: return "R8";
        endcase
    endfunction

    task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic set_bank(input logic [2:0] b);
        wr_cycle(16'h0000, 8'hFF);
        wr_cycle(16'h0001, {5'd0, b});
    endtask

    // Combinational probe with no clock edge between drive and sample.
    task automatic probe(input logic [15:0] a, input logic [2:0] b);
        int c;
        int o;
        bit lcl;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b0; cpu_wr = 1'b0;
        #1;
        c = m_code(a, b);
        o = m_off(a, c);
        lcl = (c == 6) || (c == 11) || (c == 12);
        check(int'(tgt_id) == c, m_req(c), int'(tgt_id), c);
        check(int'(tgt_off) == o, m_req(c), int'(tgt_off), o);
        check(rd_local == lcl, "R12", int'(rd_local), int'(lcl));
        if (!lcl) check(rd_data == 8'h00, "R12", int'(rd_data), 0);
        cpu_wr = 1'b1;
        #1;
        check(wr_ram == (c <= 3), "R9", int'(wr_ram), int'(c <= 3));
        cpu_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [15:0] a, input logic [7:0] mask,
                            input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        check((rd_data & mask) == exp, req, int'(rd_data & mask), int'(exp));
        cpu_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(bank_cfg == 3'b111, "R1", int'(bank_cfg), 7);
        rd_check(16'h0000, 8'hFF, 8'h00, "R1");
        rd_check(16'h0001, 8'hFF, 8'h00, "R1");

        // R11: identification sequence from reset value
        @(negedge clk);
        cpu_addr = 16'hDFFF; cpu_rd = 1'b1; #1;
        check(rd_data == 8'hAA, "R11", int'(rd_data), 8'hAA);
        @(negedge clk); #1;
        check(rd_data == 8'h55, "R11", int'(rd_data), 8'h55);
        @(negedge clk); #1;
        check(rd_data == 8'hAA, "R11", int'(rd_data), 8'hAA);
        cpu_rd = 1'b0;

        // R2 / R3-R9 / R12: full page sweep under every bank value
        for (int b = 0; b < 8; b++) begin
            set_bank(3'(b));
            #1;
            check(int'(bank_cfg) == b, "R2", int'(bank_cfg), b);
            rd_check(16'h0000, 8'hFF, 8'hFF, "R2");
            rd_check(16'h0001, 8'hFF, 8'(b), "R2");
            for (int p = 0; p < 256; p++) begin
                probe({8'(p), 8'(p * 37)}, 3'(b));
            end
            probe(16'h0000, 3'(b));
            probe(16'h0001, 3'(b));
            probe(16'hDF05, 3'(b));
            probe(16'hDF0F, 3'(b));
            probe(16'hDF10, 3'(b));
            probe(16'hDFFF, 3'(b));
        end

        // R2: inversion of the direction register in the bank value
        wr_cycle(16'h0000, 8'h05);
        wr_cycle(16'h0001, 8'h00);
        #1;
        check(bank_cfg == 3'b010, "R2", int'(bank_cfg), 2);
        probe(16'hE123, 3'b010);
        probe(16'hA010, 3'b010);
        probe(16'hD040, 3'b010);
        wr_cycle(16'h0001, 8'h04);
        #1;
        check(bank_cfg == 3'b110, "R2", int'(bank_cfg), 6);
        probe(16'hD012, 3'b110);

        // R10: colour memory keeps low nibble only
        set_bank(3'b111);
        wr_cycle(16'hD805, 8'h3C);
        wr_cycle(16'hDBFF, 8'hA7);
        rd_check(16'hD805, 8'h0F, 8'h0C, "R10");
        rd_check(16'hDBFF, 8'h0F, 8'h07, "R10");
        // R10/R9: write with character ROM mapped goes to RAM, not colour memory
        set_bank(3'b011);
        probe(16'hD805, 3'b011);
        wr_cycle(16'hD805, 8'h09);
        set_bank(3'b111);
        rd_check(16'hD805, 8'h0F, 8'h0C, "R10");

        // R11: id byte holds 0x55 now; unmapped reads and writes do not toggle
        set_bank(3'b011);
        @(negedge clk);
        cpu_addr = 16'hDFFF; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        set_bank(3'b111);
        wr_cycle(16'hDFFF, 8'h00);
        rd_check(16'hDFFF, 8'hFF, 8'hAA, "R11");

        // R1: reset mid-run restores the port registers and banking
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(bank_cfg == 3'b111, "R1", int'(bank_cfg), 7);
        rd_check(16'h0001, 8'hFF, 8'h00, "R1");
        rd_check(16'hDFFF, 8'hFF, 8'hAA, "R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule